// File: doc/BRIEF.md
# Link Reset Sequencing Controller

This block brings a serial-link endpoint and the logic around it out of reset after power-up, one reset at a time and in a fixed order. While the device configuration flag is low, every reset it drives stays asserted. Once configuration is complete, it releases the reset of the transceiver reconfiguration manager. It then waits for both transceiver calibration-busy flags to go low. After that it releases the active-low fundamental link reset, which takes the link core out of reset. In plug-in-card mode this release also waits until the fundamental reset has been held for a minimum time. The controller then waits for the core's reset-status flag to fall, and releases the application-layer reset last.

The machine has five named states. WAIT_CFG (code 0) holds all resets. WAIT_CAL (code 1) has released the manager and waits for calibration. WAIT_HOLD (code 2) has seen calibration finish and waits for the minimum hold time. WAIT_CORE (code 3) has released the link and waits for the core. RUN (code 4) has released everything and raises done.

The transitions are:
- cfg_seen: WAIT_CFG to WAIT_CAL when the configuration flag is high.
- cal_idle: WAIT_CAL to WAIT_HOLD when both synchronized busy flags are low.
- cal_again: WAIT_HOLD back to WAIT_CAL when either busy flag rises again.
- hold_met: WAIT_HOLD to WAIT_CORE when the mode is embedded, or when the hold timer has expired.
- core_ready: WAIT_CORE to RUN when the synchronized reset-status flag is low.
- A synchronous global reset returns the machine to WAIT_CFG from any state.

The calibration-busy inputs and the reset-status input are asynchronous. Each one passes through a two-flop synchronizer. In these synchronizers the busy and status flags read as high while the global reset is asserted. The minimum hold is HOLD_CYC = CLK_HZ/1000*HOLD_MS clock cycles, counted from the release of the global reset. With the default values this is 100 ms.

Top module: `link_rst_seq`

## Requirements
- R1: While cfg_done_i is low after reset, mgr_rst_o=1, link_rst_n_o=0, app_rst_o=1, done_o=0 and state_o=0 (WAIT_CFG).
- R2: The manager reset is the first one released. mgr_rst_o falls on the first clock edge that samples cfg_done_i high. At that point state_o=1 (WAIT_CAL) and link_rst_n_o is still 0.
- R3: link_rst_n_o stays 0 while either calibration-busy input is high. Each busy input reaches the machine through a two-flop synchronizer.
- R4: With plug_mode_i=0 (embedded), link_rst_n_o rises within 5 clock edges of both busy inputs going low. state_o is then 3 (WAIT_CORE) and app_rst_o is still 1.
- R5: With plug_mode_i=1, link_rst_n_o stays 0 for at least HOLD_CYC edges after the global reset is released. If configuration and calibration finished earlier, it rises within HOLD_CYC+3 edges.
- R6: app_rst_o stays 1 while core_rst_stat_i is high.
- R7: app_rst_o falls within 5 edges of core_rst_stat_i going low. state_o is then 4 (RUN).
- R8: If a busy input rises while the machine is in WAIT_HOLD, state_o returns to 1 and link_rst_n_o stays 0.
- R9: done_o rises together with the application reset release. It then stays high, and all reset outputs stay released, whatever the other inputs do, until the global reset.
- R10: The synchronous input rst, when high, returns the machine to WAIT_CFG with all resets asserted and done_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous global reset, active high |
| cfg_done_i | input | 1 | Device configuration complete |
| plug_mode_i | input | 1 | 1 = plug-in-card mode (minimum hold applies), 0 = embedded mode |
| txcal_busy_i | input | 1 | Transmit calibration busy, asynchronous |
| rxcal_busy_i | input | 1 | Receive calibration busy, asynchronous |
| core_rst_stat_i | input | 1 | Link core still in reset, asynchronous |
| mgr_rst_o | output | 1 | Reconfiguration manager reset, active high |
| link_rst_n_o | output | 1 | Fundamental link reset, active low |
| app_rst_o | output | 1 | Application-layer reset, active high |
| done_o | output | 1 | Sequence complete |
| state_o | output | 3 | Current state code |

## Verification
The bench keeps calibration busy for a long time after configuration and expects the link reset to stay held. A design that skipped the calibration wait would release the link early. In plug-in-card mode it measures the exact cycle at which the link reset releases. A timer that started late would release well past the window, and one that was ignored would release long before it. It raises a busy flag while the machine waits for the hold time and expects the machine to go back to WAIT_CAL. It toggles every input after RUN and expects done and all releases to stay put. It also pulses the global reset in the middle of the sequence, which exposes any state or timer that fails to clear.

// File: rtl/link_rst_seq_pkg.sv
package link_rst_seq_pkg;
    typedef enum logic [2:0] {
        WAIT_CFG  = 3'd0,
        WAIT_CAL  = 3'd1,
        WAIT_HOLD = 3'd2,
        WAIT_CORE = 3'd3,
        RUN       = 3'd4
    } seq_state_t;
endpackage

// File: rtl/lrs_sync2.sv
module lrs_sync2 #(
    parameter int         WIDTH   = 1,
    parameter logic [0:0] RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) begin
                    meta_q[gi] <= RST_VAL[0];
                    sync_q[gi] <= RST_VAL[0];
                end else begin
                    meta_q[gi] <= d_i[gi];
                    sync_q[gi] <= meta_q[gi];
                end
            end
        end
    endgenerate

    assign q_o = sync_q;
endmodule

// File: rtl/lrs_hold_timer.sv
module lrs_hold_timer #(
    parameter int HOLD_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic expired_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == LIMIT);

    // R5
    timer_sat_chk: assert property (@(posedge clk) disable iff (rst)
        expired_o |=> expired_o);
endmodule

// File: rtl/link_rst_seq.sv
module link_rst_seq
    import link_rst_seq_pkg::*;
#(
    parameter int CLK_HZ  = 125_000_000,
    parameter int HOLD_MS = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_done_i,
    input  logic       plug_mode_i,
    input  logic       txcal_busy_i,
    input  logic       rxcal_busy_i,
    input  logic       core_rst_stat_i,
    output logic       mgr_rst_o,
    output logic       link_rst_n_o,
    output logic       app_rst_o,
    output logic       done_o,
    output logic [2:0] state_o
);
    localparam int HOLD_CYC = (CLK_HZ / 1000) * HOLD_MS;

    seq_state_t state_q, state_d;
    logic [2:0] async_s;
    logic       busy_any;
    logic       core_busy;
    logic       hold_done;

    lrs_sync2 #(.WIDTH(3), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({core_rst_stat_i, rxcal_busy_i, txcal_busy_i}),
        .q_o (async_s)
    );

    assign busy_any  = async_s[0] | async_s[1];
    assign core_busy = async_s[2];

    lrs_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .expired_o (hold_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WAIT_CFG:  if (cfg_done_i) state_d = WAIT_CAL;
            WAIT_CAL:  if (!busy_any) state_d = WAIT_HOLD;
            WAIT_HOLD: begin
                if (busy_any)                       state_d = WAIT_CAL;
                else if (!plug_mode_i || hold_done) state_d = WAIT_CORE;
            end
            WAIT_CORE: if (!core_busy) state_d = RUN;
            RUN:       state_d = RUN;
            default:   state_d = WAIT_CFG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= WAIT_CFG;
        else     state_q <= state_d;
    end

    always_comb begin
        mgr_rst_o    = 1'b1;
        link_rst_n_o = 1'b0;
        app_rst_o    = 1'b1;
        done_o       = 1'b0;
        unique case (state_q)
            WAIT_CFG:  ;
            WAIT_CAL:  mgr_rst_o = 1'b0;
            WAIT_HOLD: mgr_rst_o = 1'b0;
            WAIT_CORE: begin
                mgr_rst_o    = 1'b0;
                link_rst_n_o = 1'b1;
            end
            RUN: begin
                mgr_rst_o    = 1'b0;
                link_rst_n_o = 1'b1;
                app_rst_o    = 1'b0;
                done_o       = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

    // R2
    mgr_first_chk: assert property (@(posedge clk) disable iff (rst)
        link_rst_n_o |-> !mgr_rst_o);
    // R3
    link_after_cal_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_rst_n_o) |-> !$past(busy_any));
    // R5
    plug_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(link_rst_n_o) && plug_mode_i) |-> $past(hold_done));
    // R7
    app_last_chk: assert property (@(posedge clk) disable iff (rst)
        !app_rst_o |-> link_rst_n_o);
    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);
endmodule

// File: tb/link_rst_seq_bench.sv
`timescale 1ns/1ps
module link_rst_seq_bench;
    localparam int CLK_HZ   = 20_000;
    localparam int HOLD_MS  = 100;
    localparam int HOLD_CYC = (CLK_HZ / 1000) * HOLD_MS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_done_i = 1'b0, plug_mode_i = 1'b0;
    logic txcal_busy_i = 1'b1, rxcal_busy_i = 1'b1, core_rst_stat_i = 1'b1;
    logic mgr_rst_o, link_rst_n_o, app_rst_o, done_o;
    logic [2:0] state_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    link_rst_seq #(.CLK_HZ(CLK_HZ), .HOLD_MS(HOLD_MS)) u_link_rst_seq (
        .clk(clk), .rst(rst), .cfg_done_i(cfg_done_i), .plug_mode_i(plug_mode_i),
        .txcal_busy_i(txcal_busy_i), .rxcal_busy_i(rxcal_busy_i),
        .core_rst_stat_i(core_rst_stat_i), .mgr_rst_o(mgr_rst_o),
        .link_rst_n_o(link_rst_n_o), .app_rst_o(app_rst_o), .done_o(done_o),
        .state_o(state_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic apply_reset(input logic plug);
        @(negedge clk);
        rst = 1'b1; cfg_done_i = 1'b0; plug_mode_i = plug;
        txcal_busy_i = 1'b1; rxcal_busy_i = 1'b1; core_rst_stat_i = 1'b1;
        cycles(3);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        apply_reset(1'b0);
        cycles(50);
        check("R1 mgr_rst", mgr_rst_o, 1);
        check("R1 link_rst_n", link_rst_n_o, 0);
        check("R1 app_rst", app_rst_o, 1);
        check("R1 done", done_o, 0);
        check("R1 state", state_o, 0);
    endtask

    task automatic t_embedded_seq();
        int n;
        @(negedge clk); cfg_done_i = 1'b1;
        cycles(1);
        check("R2 mgr_rst", mgr_rst_o, 0);
        check("R2 state", state_o, 1);
        check("R2 link_rst_n", link_rst_n_o, 0);
        @(negedge clk); txcal_busy_i = 1'b0;
        cycles(40);
        check("R3 link held rx busy", link_rst_n_o, 0);
        @(negedge clk); rxcal_busy_i = 1'b0;
        n = 0;
        while (!link_rst_n_o && n < 20) begin cycles(1); n++; end
        check("R4 link released", link_rst_n_o, 1);
        check("R4 within 5", int'(n <= 5), 1);
        check("R4 state", state_o, 3);
        check("R4 app held", app_rst_o, 1);
        cycles(30);
        check("R6 app held by status", app_rst_o, 1);
        check("R9 done low", done_o, 0);
        @(negedge clk); core_rst_stat_i = 1'b0;
        n = 0;
        while (app_rst_o && n < 20) begin cycles(1); n++; end
        check("R7 app released", app_rst_o, 0);
        check("R7 within 5", int'(n <= 5), 1);
        check("R7 state", state_o, 4);
        check("R9 done with app", done_o, 1);
    endtask

    task automatic t_done_hold();
        @(negedge clk);
        cfg_done_i = 1'b0; txcal_busy_i = 1'b1; rxcal_busy_i = 1'b1;
        core_rst_stat_i = 1'b1; plug_mode_i = 1'b1;
        cycles(20);
        check("R9 done held", done_o, 1);
        check("R9 app stays", app_rst_o, 0);
        check("R9 link stays", link_rst_n_o, 1);
        check("R9 mgr stays", mgr_rst_o, 0);
    endtask

    task automatic t_global_reset();
        @(negedge clk); rst = 1'b1;
        cycles(1);
        check("R10 state", state_o, 0);
        check("R10 done", done_o, 0);
        check("R10 mgr", mgr_rst_o, 1);
        check("R10 link", link_rst_n_o, 0);
        check("R10 app", app_rst_o, 1);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_plug_hold();
        int n;
        @(negedge clk);
        rst = 1'b1; plug_mode_i = 1'b1; cfg_done_i = 1'b1;
        txcal_busy_i = 1'b0; rxcal_busy_i = 1'b0; core_rst_stat_i = 1'b1;
        cycles(3);
        @(negedge clk); rst = 1'b0;
        n = 0;
        while (!link_rst_n_o && n < HOLD_CYC + 50) begin cycles(1); n++; end
        check("R5 not before hold", int'(n >= HOLD_CYC), 1);
        check("R5 by hold+3", int'(n <= HOLD_CYC + 3), 1);
    endtask

    task automatic t_busy_rerise();
        int n;
        apply_reset(1'b1);
        @(negedge clk); cfg_done_i = 1'b1; txcal_busy_i = 1'b0; rxcal_busy_i = 1'b0;
        cycles(20);
        check("R8 in hold wait", state_o, 2);
        @(negedge clk); txcal_busy_i = 1'b1;
        cycles(5);
        check("R8 back to cal", state_o, 1);
        check("R8 link held", link_rst_n_o, 0);
        @(negedge clk); txcal_busy_i = 1'b0;
        n = 0;
        while (!link_rst_n_o && n < HOLD_CYC + 50) begin cycles(1); n++; end
        check("R5 released after rerise", link_rst_n_o, 1);
        check("R5 not early", int'(n >= HOLD_CYC - 40), 1);
    endtask

    initial begin
        t_reset_state();
        t_embedded_seq();
        t_done_hold();
        t_global_reset();
        t_plug_hold();
        t_busy_rerise();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100_000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule